// File: doc/BRIEF.md
# Staged Display Interface Power Sequencer

This block controls how a parallel display interface is brought up and taken down in four stages: the pixel clock, the sync generators, the panel display-enable signal and the backlight PWM. Software sends single-cycle write-one strobes, one bit per stage, on separate enable and disable vectors. For each stage the block drives a gating output and a status bit. The status bit goes high only once the stage is actually running and goes low only once the stage has actually stopped, so firmware can poll status before it requests the next step.

Bring-up runs clock, then sync, then display, then PWM. Shutdown runs display, then sync, then clock, then PWM. An enable request for a stage whose predecessor reports no status is dropped, and a sticky error flag records it. The sync stage reports running only after a multi-flop synchronizer has carried a "running" indication over from the pixel clock domain. The display signal turns on at a frame boundary after a programmable number of guard frames. It turns off at the next frame boundary.

Top module: `disp_stage_seq`

## Requirements
- R1: While reset (rstN low) is asserted, and on the first cycle after it is released, every stageGate bit, every stageStatus bit and seqErr are 0.
- R2: The strobe, gate and status bit positions are fixed: bit 0 is the pixel clock, bit 1 is sync, bit 2 is display and bit 3 is PWM. An enable strobe on bit 0 sets stageGate[0] on the following clock edge, and stageStatus[0] rises one edge after that. A disable strobe on bit 0 clears both bits with the same timing.
- R3: An accepted sync enable sets stageGate[1] on the next edge. stageStatus[1] is 1 only while stageGate[1] is set, stageStatus[0] is set and pixRunning has passed through SYNC_STAGES flops. It rises one edge after the last of these conditions becomes true and falls one edge after stageGate[1] clears.
- R4: After an accepted display enable with guard value G sampled from guardFrames, stageGate[2] and stageStatus[2] rise together on the edge that samples the (G+1)-th frameEnd pulse. Earlier pulses leave them at 0.
- R5: After a display disable strobe, stageGate[2] and stageStatus[2] stay at 1 until the edge that samples the next frameEnd pulse, and both clear on that edge.
- R6: An enable strobe on bit 3 sets stageGate[3] on the next edge, and stageStatus[3] follows one edge later. A disable strobe on bit 3 clears both bits with the same timing.
- R7: An enable strobe on bit k (k = 1, 2 or 3) while stageStatus[k-1] is 0 leaves that stage's gate unchanged and sets seqErr on the next edge. seqErr then stays at 1 until reset.
- R8: A 0 bit in a strobe vector leaves that stage unchanged. When the enable and disable strobes are both set for the same stage in the same cycle, the disable takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enStrobe | input | 4 | Write-one enable request, one bit per stage |
| disStrobe | input | 4 | Write-one disable request, one bit per stage |
| frameEnd | input | 1 | Single-cycle pulse at each frame boundary |
| pixRunning | input | 1 | Running indication from the pixel clock domain (asynchronous) |
| guardFrames | input | GUARD_W | Number of guard frames before the display signal turns on |
| stageGate | output | 4 | Gating output for each stage |
| stageStatus | output | 4 | Per-stage "has taken effect" status |
| seqErr | output | 1 | Sticky out-of-order enable error |

## Verification
The bench uses the default parameters: a 4-bit guard count and a two-flop synchronizer. With these settings the bench can run guard values of 0, 1 and 3 in only a few frame pulses, and it can find the exact cycle in which sync status rises after pixRunning goes high. The tests also cover a full bring-up and the reverse shutdown, out-of-order enables, all-zero strobes and enable/disable collisions.

// File: rtl/disp_seq_pkg.sv
package disp_seq_pkg;
  localparam int NSTG    = 4;
  localparam int STG_CLK  = 0;
  localparam int STG_SYNC = 1;
  localparam int STG_DISP = 2;
  localparam int STG_PWM  = 3;

  typedef struct packed {
    logic [NSTG-1:0] turnOn;
    logic [NSTG-1:0] turnOff;
  } stageCmd_t;
endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import disp_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSTG-1:0] enStrobe,
  input  logic [NSTG-1:0] disStrobe,
  input  logic [NSTG-2:0] predStat,
  output stageCmd_t       cmd,
  output logic            seqErr
);
  logic [NSTG-1:0] predOk;
  logic            badReq;

  // Stage 0 has no predecessor; each later stage needs the one below it.
  assign predOk = {predStat, 1'b1};
  assign badReq = |(enStrobe & ~predOk);

  always_comb begin
    cmd.turnOff = disStrobe;
    cmd.turnOn  = enStrobe & predOk & ~disStrobe;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seqErr <= 1'b0;
    else if (badReq) seqErr <= 1'b1;
  end

  p_err_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    (|(enStrobe & ~{predStat, 1'b1})) |=> seqErr);
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    seqErr |=> seqErr);
endmodule

// File: rtl/seq_dpath.sv
module seq_dpath
  import disp_seq_pkg::*;
#(
  parameter int GUARD_W     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  stageCmd_t          cmd,
  input  logic               frameEnd,
  input  logic               pixRunning,
  input  logic [GUARD_W-1:0] guardFrames,
  output logic [NSTG-1:0]    stageGate,
  output logic [NSTG-1:0]    stageStatus
);
  logic clkGate, clkStat, syncGate, syncStat, dispGate, pwmGate, pwmStat;
  logic pendOn, pendOff, runSeen;
  logic [GUARD_W-1:0] guardCnt;
  logic [SYNC_STAGES-1:0] runPipe;

  // Crossing from the pixel domain: a chain of SYNC_STAGES flops.
  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) runPipe <= '0;
        else runPipe <= pixRunning;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) runPipe <= '0;
        else runPipe <= {runPipe[SYNC_STAGES-2:0], pixRunning};
    end
  endgenerate
  assign runSeen = runPipe[SYNC_STAGES-1];

  // Clock, sync and PWM stages: the gate follows the command; status lags by one cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkGate <= 1'b0; clkStat <= 1'b0;
      syncGate <= 1'b0; syncStat <= 1'b0;
      pwmGate <= 1'b0; pwmStat <= 1'b0;
    end else begin
      if (cmd.turnOff[STG_CLK]) clkGate <= 1'b0;
      else if (cmd.turnOn[STG_CLK]) clkGate <= 1'b1;
      if (cmd.turnOff[STG_SYNC]) syncGate <= 1'b0;
      else if (cmd.turnOn[STG_SYNC]) syncGate <= 1'b1;
      if (cmd.turnOff[STG_PWM]) pwmGate <= 1'b0;
      else if (cmd.turnOn[STG_PWM]) pwmGate <= 1'b1;
      clkStat  <= clkGate;
      syncStat <= syncGate & clkStat & runSeen;
      pwmStat  <= pwmGate;
    end
  end

  // Display stage: switches only at frame boundaries, after the guard frames.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dispGate <= 1'b0; pendOn <= 1'b0; pendOff <= 1'b0; guardCnt <= '0;
    end else if (cmd.turnOff[STG_DISP]) begin
      pendOn <= 1'b0;
      if (dispGate) pendOff <= 1'b1;
    end else if (cmd.turnOn[STG_DISP]) begin
      pendOff <= 1'b0;
      if (!dispGate) begin
        pendOn   <= 1'b1;
        guardCnt <= guardFrames;
      end
    end else if (frameEnd) begin
      if (pendOn) begin
        if (guardCnt == '0) begin
          dispGate <= 1'b1;
          pendOn   <= 1'b0;
        end else begin
          guardCnt <= guardCnt - 1'b1;
        end
      end
      if (pendOff) begin
        dispGate <= 1'b0;
        pendOff  <= 1'b0;
      end
    end
  end

  assign stageGate   = {pwmGate, dispGate, syncGate, clkGate};
  assign stageStatus = {pwmStat, dispGate, syncStat, clkStat};

  p_clk_stat_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkStat) |-> $past(clkGate));
  p_sync_stat_r3: assert property (@(posedge clk) disable iff (!rstN)
    syncStat |-> $past(clkStat && runSeen && syncGate));
  p_disp_on_frame_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dispGate) |-> $past(frameEnd));
  p_disp_off_frame_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dispGate) |-> $past(frameEnd));
  p_pwm_stat_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwmStat) |-> $past(pwmGate));
endmodule

// File: rtl/disp_stage_seq.sv
module disp_stage_seq
  import disp_seq_pkg::*;
#(
  parameter int GUARD_W     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [3:0]         enStrobe,
  input  logic [3:0]         disStrobe,
  input  logic               frameEnd,
  input  logic               pixRunning,
  input  logic [GUARD_W-1:0] guardFrames,
  output logic [3:0]         stageGate,
  output logic [3:0]         stageStatus,
  output logic               seqErr
);
  stageCmd_t cmd;

  seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enStrobe(enStrobe), .disStrobe(disStrobe),
    .predStat(stageStatus[NSTG-2:0]), .cmd(cmd), .seqErr(seqErr)
  );

  seq_dpath #(.GUARD_W(GUARD_W), .SYNC_STAGES(SYNC_STAGES)) u_dpath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .frameEnd(frameEnd),
    .pixRunning(pixRunning), .guardFrames(guardFrames),
    .stageGate(stageGate), .stageStatus(stageStatus)
  );

  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |=> (stageGate == 4'b0 && stageStatus == 4'b0 && !seqErr));
endmodule

// File: tb/disp_stage_seq_test.sv
module disp_stage_seq_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] enStrobe = '0, disStrobe = '0;
  logic frameEnd = 1'b0, pixRunning = 1'b0;
  logic [3:0] guardFrames = 4'd1;
  logic [3:0] stageGate, stageStatus;
  logic seqErr;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  disp_stage_seq uut (
    .clk(clk), .rstN(rstN), .enStrobe(enStrobe), .disStrobe(disStrobe),
    .frameEnd(frameEnd), .pixRunning(pixRunning), .guardFrames(guardFrames),
    .stageGate(stageGate), .stageStatus(stageStatus), .seqErr(seqErr)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input logic [3:0] en, input logic [3:0] dis, input logic fe);
    @(negedge clk);
    enStrobe = en; disStrobe = dis; frameEnd = fe;
    @(negedge clk);
    enStrobe = '0; disStrobe = '0; frameEnd = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    tick(2);
    check("R1 gates in reset", {4'b0, stageGate}, 8'h00);
    check("R1 status in reset", {3'b0, seqErr, stageStatus}, 8'h00);
    rstN = 1'b1;
    tick();
    check("R1 after release", {3'b0, seqErr, stageStatus | stageGate}, 8'h00);
  endtask

  task automatic t_order_errors();
    doReset();
    drive(4'b0010, 4'b0000, 1'b0);
    check("R7 sync without clock ignored", {4'b0, stageGate}, 8'h00);
    check("R7 error set", {7'b0, seqErr}, 8'h01);
    drive(4'b0001, 4'b0000, 1'b0);
    tick();
    drive(4'b1000, 4'b0000, 1'b0);
    tick();
    check("R7 pwm without display ignored", {4'b0, stageGate}, 8'h01);
    check("R7 error sticky", {7'b0, seqErr}, 8'h01);
    doReset();
  endtask

  task automatic t_bringup();
    pixRunning = 1'b1;
    guardFrames = 4'd1;
    doReset();
    tick(3);
    drive(4'b0001, 4'b0000, 1'b0);
    check("R2 clock gate on", {4'b0, stageGate}, 8'h01);
    check("R2 clock status lags gate", {4'b0, stageStatus}, 8'h00);
    tick();
    check("R2 clock status on", {4'b0, stageStatus}, 8'h01);
    drive(4'b0010, 4'b0000, 1'b0);
    check("R3 sync gate on", {4'b0, stageGate}, 8'h03);
    tick();
    check("R3 sync status on", {4'b0, stageStatus}, 8'h03);
    drive(4'b0100, 4'b0000, 1'b0);
    check("R4 display waits for frames", {4'b0, stageGate}, 8'h03);
    drive(4'b0000, 4'b0000, 1'b1);
    check("R4 guard frame 1 still off", {4'b0, stageGate}, 8'h03);
    drive(4'b0000, 4'b0000, 1'b1);
    check("R4 display on after guard", {stageStatus, stageGate}, 8'h77);
    drive(4'b1000, 4'b0000, 1'b0);
    check("R6 pwm gate on", {4'b0, stageGate}, 8'h0F);
    tick();
    check("R6 pwm status on", {3'b0, seqErr, stageStatus}, 8'h0F);
  endtask

  task automatic t_zero_bits();
    drive(4'b0000, 4'b0000, 1'b0);
    tick(2);
    check("R8 zero strobes no change", {stageStatus, stageGate}, 8'hFF);
  endtask

  task automatic t_shutdown();
    drive(4'b0000, 4'b0100, 1'b0);
    tick(3);
    check("R5 display held until frame end", {stageStatus, stageGate}, 8'hFF);
    drive(4'b0000, 4'b0000, 1'b1);
    check("R5 display off at frame end", {stageStatus, stageGate}, 8'hBB);
    drive(4'b0000, 4'b0010, 1'b0);
    tick();
    check("R3 sync status off", {stageStatus, stageGate}, 8'h99);
    drive(4'b0000, 4'b0001, 1'b0);
    tick();
    check("R2 clock off", {stageStatus, stageGate}, 8'h88);
    drive(4'b0000, 4'b1000, 1'b0);
    tick();
    check("R6 pwm off", {stageStatus, stageGate}, 8'h00);
  endtask

  task automatic t_sync_wait();
    pixRunning = 1'b0;
    doReset();
    drive(4'b0001, 4'b0000, 1'b0);
    tick();
    drive(4'b0010, 4'b0000, 1'b0);
    tick(4);
    check("R3 no status without pixel run", {stageStatus, stageGate}, 8'h13);
    pixRunning = 1'b1;
    tick(2);
    check("R3 still off during synchronizer", {4'b0, stageStatus}, 8'h01);
    tick();
    check("R3 on after synchronizer", {4'b0, stageStatus}, 8'h03);
  endtask

  task automatic t_guard_values();
    guardFrames = 4'd3;
    drive(4'b0100, 4'b0000, 1'b0);
    guardFrames = 4'd0;
    for (int i = 0; i < 3; i++) drive(4'b0000, 4'b0000, 1'b1);
    check("R4 guard 3 off after 3 frames", {4'b0, stageGate}, 8'h03);
    drive(4'b0000, 4'b0000, 1'b1);
    check("R4 guard 3 on at 4th frame", {stageStatus, stageGate}, 8'h77);
    drive(4'b0000, 4'b0100, 1'b0);
    drive(4'b0000, 4'b0000, 1'b1);
    drive(4'b0100, 4'b0000, 1'b0);
    check("R4 guard 0 waits for a frame", {4'b0, stageGate}, 8'h03);
    drive(4'b0000, 4'b0000, 1'b1);
    check("R4 guard 0 on at first frame", {stageStatus, stageGate}, 8'h77);
  endtask

  task automatic t_collision();
    drive(4'b1000, 4'b1000, 1'b0);
    tick();
    check("R8 disable wins over enable", {stageStatus, stageGate}, 8'h77);
    check("R8 no error on legal collision", {7'b0, seqErr}, 8'h00);
  endtask

  initial begin
    rstN = 1'b0;
    tick(2);
    t_order_errors();
    t_bringup();
    t_zero_bits();
    t_shutdown();
    t_sync_wait();
    t_guard_values();
    t_collision();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired got=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule